// File: doc/BRIEF.md
# Subtract-From Execution Unit

This unit decodes and executes one reversed-operand subtract instruction held in a 32-bit word. A word qualifies only if it carries primary opcode 31 and extended opcode 40. Source A and source B arrive as 64-bit values in the same cycle as the word. The unit returns B minus A, the destination index and a write-enable. It also exposes the two source-register selects as combinational outputs, so that a register file outside the unit can read the operands.

The unit holds three status bits: overflow, sticky summary-overflow and carry. It also holds a four-bit condition field. The overflow-enable flag in the word decides whether the overflow bits move. The record flag decides whether the condition field is rewritten. A separate status write port presets the status bits. A valid word that fails the opcode match is flagged and changes nothing. Every result, status change and condition change appears one clock after the input.

Top module: `sfx_unit`

## Requirements
- R1: A valid word is legal when bits [31:26] equal 31 and bits [9:1] equal 40. One clock later, `out_wen` is 1 for a legal word.
- R2: The word's fields are placed as follows: destination index in bits [25:21], source-A select in [20:16], source-B select in [15:11], overflow-enable in bit 10, record flag in bit 0. `sel_a` and `sel_b` follow the word combinationally.
- R3: `out_result` equals src_b minus src_a modulo 2^64. It is computed as the complement of A plus B plus 1.
- R4: Signed overflow is bit 63 of ((A xor B) and (B xor result)). With overflow-enable set, `xer_ov` takes this value and `xer_so` becomes its old value OR the overflow.
- R5: With overflow-enable clear, `xer_ov` and `xer_so` keep their values.
- R6: Once `xer_so` is set, an instruction cannot clear it, even one with overflow-enable set and no overflow.
- R7: An instruction never changes `xer_ca`. Only the status write port or reset changes it.
- R8: With the record flag set, `cr0` = {LT, GT, EQ, SO}, MSB first. LT, GT and EQ come from a signed compare of the result with zero. SO is the summary-overflow value after this instruction's own update.
- R9: With the record flag clear, `cr0` keeps its value.
- R10: A valid word that is not legal drives `out_illegal` high and `out_wen` low one clock later. It changes no status bit and no `cr0` bit.
- R11: A synchronous active-low reset clears `out_wen`, `out_illegal`, all status bits and `cr0`.
- R12: When `sts_wr_en` is high, `sts_wr_data` = {SO, OV, CA} is loaded. A legal instruction in the same cycle applies its update on top of the written values.
- R13: In a cycle without `in_valid`, `out_wen` and `out_illegal` are low one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction word valid |
| in_instr | input | 32 | Instruction word |
| src_a | input | 64 | Source A value |
| src_b | input | 64 | Source B value |
| sts_wr_en | input | 1 | Load the status bits |
| sts_wr_data | input | 3 | Status load value {SO, OV, CA} |
| sel_a | output | 5 | Source-A register select (combinational) |
| sel_b | output | 5 | Source-B register select (combinational) |
| out_wen | output | 1 | Destination write-enable |
| out_rd | output | 5 | Destination register index |
| out_result | output | 64 | B minus A |
| out_illegal | output | 1 | Valid word failed the opcode match |
| xer_so | output | 1 | Summary-overflow, sticky |
| xer_ov | output | 1 | Overflow |
| xer_ca | output | 1 | Carry, never touched by instructions |
| cr0 | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
Two functions can act in the same cycle: a status load from the write port and an overflow update from a legal instruction. The bench provokes this directly and also hits it at random. It checks that the written summary-overflow value is OR-ed with the new overflow, and that a recorded condition field carries that merged bit. The same merge matters when a preset summary-overflow meets an instruction that does not overflow: the bench expects overflow cleared, summary-overflow held, and SO set in the condition field.

// File: rtl/sfx_pkg.sv
// Shared constants and types for the subtract-from unit.
// Assumes big-endian field numbering, mapped onto little-endian vector bits.
package sfx_pkg;
    localparam int INSN_W  = 32;
    localparam int IDX_W   = 5;
    localparam int CR_W    = 4;
    localparam logic [5:0] PRI_OP = 6'd31;
    localparam logic [8:0] EXT_OP = 9'd40;
    // Condition field bit positions
    localparam int CR_LT = 3;
    localparam int CR_GT = 2;
    localparam int CR_EQ = 1;
    localparam int CR_SO = 0;

    // Status bits, packed {so, ov, ca}
    typedef struct packed {
        logic so;
        logic ov;
        logic ca;
    } sfx_sts_t;
endpackage

// File: rtl/sfx_decode.sv
// Field extraction and opcode match for the subtract-from word.
// Purely combinational; assumes the word is stable while in_valid is high.
module sfx_decode
    import sfx_pkg::*;
(
    input  logic [INSN_W-1:0] instr,
    output logic              match,
    output logic [IDX_W-1:0]  rd,
    output logic [IDX_W-1:0]  ra,
    output logic [IDX_W-1:0]  rb,
    output logic              oe,
    output logic              rc
);
    logic [5:0] pri;
    logic [8:0] ext;

    // Slice out the fields and compare the opcode pair
    always_comb begin
        pri   = instr[31:26];
        rd    = instr[25:21];
        ra    = instr[20:16];
        rb    = instr[15:11];
        oe    = instr[10];
        ext   = instr[9:1];
        rc    = instr[0];
        match = (pri == PRI_OP) && (ext == EXT_OP);
    end
endmodule

// File: rtl/sfx_datapath.sv
// Complement-add subtractor with signed-overflow and zero-compare flags.
// Combinational; result = ~a + b + 1 = b - a, truncated to XLEN bits.
module sfx_datapath #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] diff,
    output logic            ovf,
    output logic            lt,
    output logic            gt,
    output logic            eq
);
    localparam int MSB = XLEN - 1;
    logic [XLEN-1:0] ovf_vec;

    // Complement-add and flag derivation
    always_comb begin
        diff    = ~a + b + {{(XLEN-1){1'b0}}, 1'b1};
        ovf_vec = (a ^ b) & (b ^ diff);
        ovf     = ovf_vec[MSB];
        lt      = diff[MSB];
        eq      = (diff == '0);
        gt      = !lt && !eq;
    end
endmodule

// File: rtl/sfx_status.sv
// Status bits (summary-overflow, overflow, carry) and condition field 0.
// A status load is applied first; an instruction update is merged on top.
// Synchronous active-low reset clears everything.
module sfx_status
    import sfx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  sfx_sts_t        wr_sts,
    input  logic            upd_en,
    input  logic            ovf,
    input  logic            rec_en,
    input  logic            lt,
    input  logic            gt,
    input  logic            eq,
    output sfx_sts_t        sts,
    output logic [CR_W-1:0] cr0
);
    sfx_sts_t        base_sts;
    sfx_sts_t        nxt_sts;
    logic [CR_W-1:0] nxt_cr;

    // Next status: load first, then overflow update
    always_comb begin
        base_sts = wr_en ? wr_sts : sts;
        nxt_sts  = base_sts;
        if (upd_en) begin
            nxt_sts.ov = ovf;
            nxt_sts.so = base_sts.so | ovf;
        end
        nxt_cr = cr0;
        if (rec_en) begin
            nxt_cr[CR_LT] = lt;
            nxt_cr[CR_GT] = gt;
            nxt_cr[CR_EQ] = eq;
            nxt_cr[CR_SO] = nxt_sts.so;
        end
    end

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts <= '0;
            cr0 <= '0;
        end else begin
            sts <= nxt_sts;
            cr0 <= nxt_cr;
        end
    end

    a_r7_ca_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(sts.ca));
    a_r6_so_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sts.so && !wr_en) |=> sts.so);
    a_r5_ov_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_en && !wr_en) |=> ($stable(sts.ov) && $stable(sts.so)));
    a_r8_cr_so_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rec_en |=> (cr0[CR_SO] == sts.so));
    a_r8_cr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        rec_en |=> $onehot(cr0[CR_LT:CR_EQ]));
    a_r9_cr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rec_en |=> $stable(cr0));
endmodule

// File: rtl/sfx_unit.sv
// Top of the subtract-from execution unit.
// Decodes the word, computes b - a, updates status and condition field,
// and registers writeback outputs so all effects appear one clock later.
module sfx_unit
    import sfx_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [INSN_W-1:0]      in_instr,
    input  logic [XLEN-1:0]        src_a,
    input  logic [XLEN-1:0]        src_b,
    input  logic                   sts_wr_en,
    input  logic [2:0]             sts_wr_data,
    output logic [IDX_W-1:0]       sel_a,
    output logic [IDX_W-1:0]       sel_b,
    output logic                   out_wen,
    output logic [IDX_W-1:0]       out_rd,
    output logic [XLEN-1:0]        out_result,
    output logic                   out_illegal,
    output logic                   xer_so,
    output logic                   xer_ov,
    output logic                   xer_ca,
    output logic [CR_W-1:0]        cr0
);
    logic             match, oe, rc, hit;
    logic [IDX_W-1:0] rd;
    logic [XLEN-1:0]  diff;
    logic             ovf, lt, gt, eq;
    sfx_sts_t         sts;

    sfx_decode u_dec (
        .instr (in_instr),
        .match (match),
        .rd    (rd),
        .ra    (sel_a),
        .rb    (sel_b),
        .oe    (oe),
        .rc    (rc)
    );

    sfx_datapath #(.XLEN(XLEN)) u_dp (
        .a    (src_a),
        .b    (src_b),
        .diff (diff),
        .ovf  (ovf),
        .lt   (lt),
        .gt   (gt),
        .eq   (eq)
    );

    // Qualify the decode with the valid strobe
    always_comb hit = in_valid && match;

    sfx_status u_sts (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (sts_wr_en),
        .wr_sts (sfx_sts_t'(sts_wr_data)),
        .upd_en (hit && oe),
        .ovf    (ovf),
        .rec_en (hit && rc),
        .lt     (lt),
        .gt     (gt),
        .eq     (eq),
        .sts    (sts),
        .cr0    (cr0)
    );

    // Expose the status bits as plain ports
    always_comb begin
        xer_so = sts.so;
        xer_ov = sts.ov;
        xer_ca = sts.ca;
    end

    // Writeback stage registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_wen     <= 1'b0;
            out_illegal <= 1'b0;
            out_rd      <= '0;
            out_result  <= '0;
        end else begin
            out_wen     <= hit;
            out_illegal <= in_valid && !match;
            if (hit) begin
                out_rd     <= rd;
                out_result <= diff;
            end
        end
    end

    a_r10_illegal_excl: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> !out_wen);
    a_r1_legal_writes: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> out_wen);
    a_r3_diff_sum: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> ((out_result + $past(src_a)) == $past(src_b)));
    a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_wen && !out_illegal));
endmodule

// File: tb/sfx_unit_test.sv
`timescale 1ns/1ps
module sfx_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_instr = '0;
    logic [63:0] src_a = '0, src_b = '0;
    logic        sts_wr_en = 1'b0;
    logic [2:0]  sts_wr_data = '0;
    logic [4:0]  sel_a, sel_b, out_rd;
    logic        out_wen, out_illegal, xer_so, xer_ov, xer_ca;
    logic [63:0] out_result;
    logic [3:0]  cr0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model of architectural state
    logic       m_so = 0, m_ov = 0, m_ca = 0;
    logic [3:0] m_cr = '0;

    localparam logic [63:0] MINV = 64'h8000_0000_0000_0000;
    localparam logic [63:0] MAXV = 64'h7FFF_FFFF_FFFF_FFFF;

    sfx_unit uut (.*);

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [4:0] rd, input logic [4:0] ra,
                                       input logic [4:0] rb, input logic oe, input logic rc);
        return {6'd31, rd, ra, rb, oe, 9'd40, rc};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // One cycle of stimulus, model update and output comparison
    task automatic step(input logic vld, input logic [31:0] w, input logic [63:0] a,
                        input logic [63:0] b, input logic wr, input logic [2:0] wd);
        logic legal, ovf, so_n;
        logic [63:0] r;
        @(negedge clk);
        in_valid = vld; in_instr = w; src_a = a; src_b = b;
        sts_wr_en = wr; sts_wr_data = wd;
        #1;
        chk(sel_a == w[20:16], "R2 sel_a", 64'(sel_a), 64'(w[20:16]));
        chk(sel_b == w[15:11], "R2 sel_b", 64'(sel_b), 64'(w[15:11]));
        legal = (w[31:26] == 6'd31) && (w[9:1] == 9'd40);
        r = b - a;
        ovf = (a[63] != b[63]) && (r[63] != b[63]);
        if (wr) begin m_so = wd[2]; m_ov = wd[1]; m_ca = wd[0]; end
        if (vld && legal && w[10]) begin
            m_ov = ovf;
            so_n = m_so | ovf;
            m_so = so_n;
        end
        if (vld && legal && w[0])
            m_cr = {r[63], !r[63] && (r != 0), r == 0, m_so};
        @(posedge clk); #2;
        if (!vld) begin
            chk(!out_wen && !out_illegal, "R13 idle outputs", {out_wen, out_illegal}, 0);
        end else if (legal) begin
            chk(out_wen && !out_illegal, "R1 legal write", {out_wen, out_illegal}, 2'b10);
            chk(out_rd == w[25:21], "R2 dest index", 64'(out_rd), 64'(w[25:21]));
            chk(out_result == r, "R3 result", out_result, r);
        end else begin
            chk(!out_wen && out_illegal, "R10 illegal flag", {out_wen, out_illegal}, 2'b01);
        end
        chk(xer_ov == m_ov, "R4/R5 ov", 64'(xer_ov), 64'(m_ov));
        chk(xer_so == m_so, "R4/R6 so", 64'(xer_so), 64'(m_so));
        chk(xer_ca == m_ca, "R7 ca", 64'(xer_ca), 64'(m_ca));
        chk(cr0 == m_cr, "R8/R9 cr0", 64'(cr0), 64'(m_cr));
    endtask

    function automatic logic [63:0] pick();
        case ($urandom % 5)
            0: return {$urandom, $urandom};
            1: return 64'($urandom % 8);
            2: return MINV;
            3: return MAXV;
            default: return {$urandom, $urandom} | MINV;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #2;
        // R11 reset state
        chk(!out_wen && !out_illegal, "R11 reset outputs", {out_wen, out_illegal}, 0);
        chk({xer_so, xer_ov, xer_ca} == 3'b000, "R11 reset status", {xer_so, xer_ov, xer_ca}, 0);
        chk(cr0 == 4'b0, "R11 reset cr0", 64'(cr0), 0);
        @(negedge clk); rst_n = 1'b1;

        // R1/R3 base encoding, A equal to B gives zero and EQ
        chk(mk(0, 0, 0, 0, 0) == 32'h7C00_0050, "R1 base encoding", mk(0,0,0,0,0), 32'h7C00_0050);
        step(1, mk(5, 1, 2, 1, 1), 64'd77, 64'd77, 0, 0);
        chk(cr0 == 4'b0010, "R8 A equal B EQ", 64'(cr0), 4'b0010);
        // R4 A most negative, B zero: overflow
        step(1, mk(6, 3, 4, 1, 1), MINV, 64'd0, 0, 0);
        chk(xer_ov && xer_so, "R4 min minus overflow", {xer_ov, xer_so}, 2'b11);
        // R6 sticky SO with OE set and no overflow
        step(1, mk(7, 3, 4, 1, 1), 64'd1, 64'd3, 0, 0);
        chk(!xer_ov && xer_so && cr0 == 4'b0101, "R6 sticky so", {xer_ov, xer_so, cr0}, 6'b010101);
        // R12 clear via write, then B most negative, A one
        step(0, 0, 0, 0, 1, 3'b001);
        step(1, mk(8, 9, 10, 1, 0), 64'd1, MINV, 0, 0);
        chk(out_result == MAXV && xer_ov, "R4 max wrap overflow", out_result, MAXV);
        // R12 preset SO through the write port, no new overflow
        step(1, mk(9, 1, 1, 1, 1), 64'd5, 64'd2, 1, 3'b100);
        chk(!xer_ov && xer_so && cr0[0], "R12 preset so merge", {xer_ov, xer_so, cr0[0]}, 3'b011);
        // R12 write and overflow in the same cycle: written SO=0 OR overflow
        step(1, mk(2, 1, 1, 1, 1), MINV, 64'd5, 1, 3'b001);
        chk(xer_so && xer_ca && cr0[0], "R12 same cycle merge", {xer_so, xer_ca, cr0[0]}, 3'b111);
        // R5 OE clear leaves bits, R9 Rc clear leaves cr0
        step(1, mk(3, 1, 1, 0, 0), MINV, 64'd0, 1, 3'b000);
        chk(!xer_ov && !xer_so, "R5 oe clear", {xer_ov, xer_so}, 0);
        // R10 illegal words
        step(1, 32'h7C00_0052, 64'd1, 64'd9, 0, 0);
        step(1, 32'h7800_0051, MINV, 64'd0, 0, 0);
        step(0, 0, 0, 0, 0, 0);

        // Constrained random mix
        for (int i = 0; i < 600; i++) begin
            logic [31:0] w;
            w = mk(5'($urandom), 5'($urandom), 5'($urandom), 1'($urandom), 1'($urandom));
            if ($urandom % 8 == 0) w = w ^ (32'd1 << (($urandom % 2) ? (26 + $urandom % 6) : (1 + $urandom % 9)));
            step(($urandom % 10) != 0, w, pick(), pick(), ($urandom % 7) == 0, 3'($urandom));
        end
        step(0, 0, 0, 0, 0, 0);
        finish_run();
    end
endmodule